// File: doc/BRIEF.md
# Mel Filter Bank Energy Accumulator

This block turns the power spectrum of one frame into a bank of mel-spaced band energies. It takes one multiplier per bin. The spectral front end supplies one power value per frequency bin, in ascending bin order, each tagged with its bin address. After the last bin of each band, the block emits that band's energy with a small index.

The filters are overlapping triangles. Each triangle reaches its peak of one at the bin where its neighbour's triangle begins. Because of this, at any bin the two triangles that overlap there have weights that sum to exactly one. The block therefore stores only the weight of the odd-numbered filter. The odd contribution is the power times that weight. The even contribution is the power minus the odd contribution.

Two accumulators take these two contributions. A table of band edges, indexed by bin address, tells each accumulator when to release its sum and start again from zero. The released sums of the two accumulators are merged into one output stream, in ascending filter order. Out-of-band bins are discarded, so no frame-level sequencer is needed.

Top module: `mfb_bank`

## Requirements
- R1: Band edges are e(j) = LO_BIN + ((HI_BIN-LO_BIN)*j*(j+WARP)) / ((NUM_FILT+1)*(NUM_FILT+1+WARP)), using integer division, for j = 0..NUM_FILT+1. Filter f (1..NUM_FILT) rises over bins e(f-1)..e(f)-1 and falls over bins e(f)..e(f+1)-1. For each frame sent as bins 0..NUM_BINS-1 in ascending order, exactly NUM_FILT results appear. They carry out_idx = 1, 2, ..., NUM_FILT in that order, and the index is a plain binary filter number.
- R2: Rising weight r(b) = ((b-e(j))*65536)/(e(j+1)-e(j)) for b in segment j. On a rising side the filter's weight is r; on a falling side it is 65536-r. An odd filter's energy is the sum over its bins of floor(X*w/65536).
- R3: An even filter's energy is the sum over its bins of X - floor(X*w_odd/65536). Here w_odd = 65536 - w_even is the weight of the overlapping odd filter.
- R4: Bins below e(0) or at or above e(NUM_FILT+1) contribute to no filter. A frame made only of such bins produces no output and leaves no residue in later results.
- R5: The result of filter f has out_valid high for one cycle. It is registered on the second rising edge after the edge that samples bin e(f+1)-1.
- R6: Cycles with in_valid low between bins are ignored, whatever in_bin and in_pwr hold. Results and their timing relative to the last bin are unchanged.
- R7: After a complete frame both accumulators are back at zero, so frames sent back to back give independent results.
- R8: While rst_n is low, out_valid is low. A frame cut short by reset leaves nothing behind, and the next full frame gives exact results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A bin is present this cycle |
| in_bin | input | ADDR_W | Bin address (log2 NUM_BINS) |
| in_pwr | input | PWR_W | Unsigned bin power |
| out_valid | output | 1 | One-cycle strobe per filter result |
| out_idx | output | IDX_W | Filter number, 1..NUM_FILT |
| out_energy | output | ACC_W | Accumulated filter energy |

## Verification
The bench builds full 24-filter weights from the edge formula and compares every filter of every frame, both value and arrival cycle. A design that handed an accumulator's sum to the wrong filter, or swapped rising and falling sides between odd and even segments, would be off on every even filter. A design that failed to gate the first segment's even half, or the last segment's odd half, would add stray power into filter 2 or leave a non-zero accumulator, and the next frame would come out wrong. Frames of out-of-band power, bins separated by idle cycles carrying junk data, back-to-back frames, and a reset in mid-frame each target one of these leak paths.

// File: rtl/mfb_pkg.sv
package mfb_pkg;

   localparam int W_FRAC = 16;
   localparam int W_W    = W_FRAC + 1;
   localparam int W_ONE  = 1 << W_FRAC;

   function automatic int edge_bin(int j, int lo, int hi, int nf, int warp);
      return lo + ((hi - lo) * j * (j + warp)) / ((nf + 1) * (nf + 1 + warp));
   endfunction

   // segment holding bin b, or -1 when b lies outside the band
   function automatic int seg_of(int b, int lo, int hi, int nf, int warp);
      int s;
      s = -1;
      for (int j = 0; j <= nf; j++)
         if (b >= edge_bin(j, lo, hi, nf, warp) && b < edge_bin(j + 1, lo, hi, nf, warp))
            s = j;
      return s;
   endfunction

   function automatic int odd_wt(int b, int lo, int hi, int nf, int warp);
      int s, e0, span, r;
      s = seg_of(b, lo, hi, nf, warp);
      if (s < 0) return 0;
      e0   = edge_bin(s, lo, hi, nf, warp);
      span = edge_bin(s + 1, lo, hi, nf, warp) - e0;
      r    = ((b - e0) * W_ONE) / span;
      return (s % 2 == 0) ? r : W_ONE - r;
   endfunction

   function automatic bit seg_end(int b, int lo, int hi, int nf, int warp);
      int s;
      s = seg_of(b, lo, hi, nf, warp);
      return (s >= 0) && (b == edge_bin(s + 1, lo, hi, nf, warp) - 1);
   endfunction

   function automatic bit edges_ok(int lo, int hi, int nf, int warp);
      bit ok;
      ok = 1'b1;
      for (int j = 0; j <= nf; j++)
         if (edge_bin(j + 1, lo, hi, nf, warp) <= edge_bin(j, lo, hi, nf, warp))
            ok = 1'b0;
      return ok;
   endfunction

endpackage

// File: rtl/mfb_coef_rom.sv
module mfb_coef_rom
   import mfb_pkg::*;
#(
   parameter int NUM_BINS = 256,
   parameter int LO_BIN   = 2,
   parameter int HI_BIN   = 254,
   parameter int NUM_FILT = 24,
   parameter int WARP     = 8,
   parameter int PWR_W    = 24,
   parameter int ADDR_W   = 8,
   parameter int SEG_W    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [ADDR_W-1:0] in_bin,
   input  logic [PWR_W-1:0]  in_pwr,
   output logic              s1_valid,
   output logic [PWR_W-1:0]  s1_pwr,
   output logic [W_W-1:0]    s1_wt,
   output logic [SEG_W-1:0]  s1_seg,
   output logic              s1_end
);

   logic [W_W-1:0]   wt_tab  [NUM_BINS];
   logic [SEG_W-1:0] seg_tab [NUM_BINS];
   logic             band_tab[NUM_BINS];
   logic             end_tab [NUM_BINS];

   for (genvar b = 0; b < NUM_BINS; b++) begin : g_tab
      localparam int SEG = seg_of(b, LO_BIN, HI_BIN, NUM_FILT, WARP);
      localparam int WT  = odd_wt(b, LO_BIN, HI_BIN, NUM_FILT, WARP);
      localparam bit LST = seg_end(b, LO_BIN, HI_BIN, NUM_FILT, WARP);
      assign wt_tab[b]   = W_W'(WT);
      assign seg_tab[b]  = SEG_W'((SEG < 0) ? 0 : SEG);
      assign band_tab[b] = (SEG >= 0);
      assign end_tab[b]  = LST;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_pwr   <= '0;
         s1_wt    <= '0;
         s1_seg   <= '0;
         s1_end   <= 1'b0;
      end else begin
         s1_valid <= in_valid & band_tab[in_bin];
         s1_pwr   <= in_pwr;
         s1_wt    <= wt_tab[in_bin];
         s1_seg   <= seg_tab[in_bin];
         s1_end   <= end_tab[in_bin];
      end
   end

endmodule

// File: rtl/mfb_mul.sv
module mfb_mul
   import mfb_pkg::*;
#(
   parameter int PWR_W = 24,
   parameter int SEG_W = 5,
   localparam int PROD_W = PWR_W + W_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s1_valid,
   input  logic [PWR_W-1:0]  s1_pwr,
   input  logic [W_W-1:0]    s1_wt,
   input  logic [SEG_W-1:0]  s1_seg,
   input  logic              s1_end,
   output logic              s2_valid,
   output logic [PWR_W-1:0]  s2_pwr,
   output logic [PROD_W-1:0] s2_prod,
   output logic [SEG_W-1:0]  s2_seg,
   output logic              s2_end
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_valid <= 1'b0;
         s2_pwr   <= '0;
         s2_prod  <= '0;
         s2_seg   <= '0;
         s2_end   <= 1'b0;
      end else begin
         s2_valid <= s1_valid;
         s2_pwr   <= s1_pwr;
         s2_prod  <= PROD_W'(s1_pwr) * PROD_W'(s1_wt);
         s2_seg   <= s1_seg;
         s2_end   <= s1_end;
      end
   end

endmodule

// File: rtl/mfb_acc_pair.sv
module mfb_acc_pair
   import mfb_pkg::*;
#(
   parameter int NUM_FILT = 24,
   parameter int PWR_W    = 24,
   parameter int SEG_W    = 5,
   parameter int ACC_W    = 40,
   localparam int PROD_W  = PWR_W + W_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s2_valid,
   input  logic [PWR_W-1:0]  s2_pwr,
   input  logic [PROD_W-1:0] s2_prod,
   input  logic [SEG_W-1:0]  s2_seg,
   input  logic              s2_end,
   output logic              out_valid,
   output logic [SEG_W-1:0]  out_idx,
   output logic [ACC_W-1:0]  out_energy
);

   logic [PWR_W-1:0] odd_part, even_part, odd_g, even_g;
   logic [ACC_W-1:0] acc_odd, acc_even, sum_odd, sum_even;
   logic             dump, dump_odd, dump_even;

   always_comb begin
      odd_part  = s2_prod[W_FRAC +: PWR_W];
      even_part = s2_pwr - odd_part;
      // first segment has no even filter, last segment has no odd filter
      odd_g     = (s2_valid && s2_seg != SEG_W'(NUM_FILT)) ? odd_part  : '0;
      even_g    = (s2_valid && s2_seg != '0)               ? even_part : '0;
      sum_odd   = acc_odd  + ACC_W'(odd_g);
      sum_even  = acc_even + ACC_W'(even_g);
      dump      = s2_valid & s2_end & (s2_seg != '0);
      dump_odd  = dump &  s2_seg[0];
      dump_even = dump & ~s2_seg[0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_odd    <= '0;
         acc_even   <= '0;
         out_valid  <= 1'b0;
         out_idx    <= '0;
         out_energy <= '0;
      end else begin
         acc_odd    <= dump_odd  ? '0 : sum_odd;
         acc_even   <= dump_even ? '0 : sum_even;
         out_valid  <= dump;
         out_idx    <= s2_seg;
         out_energy <= s2_seg[0] ? sum_odd : sum_even;
      end
   end

endmodule

// File: rtl/mfb_bank.sv
module mfb_bank
   import mfb_pkg::*;
#(
   parameter int NUM_BINS = 256,
   parameter int LO_BIN   = 2,
   parameter int HI_BIN   = 254,
   parameter int NUM_FILT = 24,
   parameter int WARP     = 8,
   parameter int PWR_W    = 24,
   parameter int ACC_W    = 40,
   localparam int ADDR_W  = $clog2(NUM_BINS),
   localparam int IDX_W   = $clog2(NUM_FILT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [ADDR_W-1:0] in_bin,
   input  logic [PWR_W-1:0]  in_pwr,
   output logic              out_valid,
   output logic [IDX_W-1:0]  out_idx,
   output logic [ACC_W-1:0]  out_energy
);

   localparam int PROD_W = PWR_W + W_W;

   if (NUM_FILT < 2 || NUM_FILT % 2 != 0) begin : g_bad_filt
      $error("NUM_FILT must be even and at least 2");
   end
   if ((1 << ADDR_W) != NUM_BINS) begin : g_bad_bins
      $error("NUM_BINS must be a power of two");
   end
   if (LO_BIN < 0 || HI_BIN > NUM_BINS || LO_BIN >= HI_BIN) begin : g_bad_band
      $error("band limits must satisfy 0 <= LO_BIN < HI_BIN <= NUM_BINS");
   end
   if (!edges_ok(LO_BIN, HI_BIN, NUM_FILT, WARP)) begin : g_bad_edges
      $error("band too narrow: filter edges are not strictly increasing");
   end
   if (ACC_W <= PWR_W) begin : g_bad_acc
      $error("ACC_W must exceed PWR_W");
   end

   logic              s1_valid, s1_end, s2_valid, s2_end;
   logic [PWR_W-1:0]  s1_pwr, s2_pwr;
   logic [W_W-1:0]    s1_wt;
   logic [IDX_W-1:0]  s1_seg, s2_seg;
   logic [PROD_W-1:0] s2_prod;

   mfb_coef_rom #(
      .NUM_BINS(NUM_BINS), .LO_BIN(LO_BIN), .HI_BIN(HI_BIN), .NUM_FILT(NUM_FILT),
      .WARP(WARP), .PWR_W(PWR_W), .ADDR_W(ADDR_W), .SEG_W(IDX_W)
   ) i_rom (
      .clk, .rst_n, .in_valid, .in_bin, .in_pwr,
      .s1_valid, .s1_pwr, .s1_wt, .s1_seg, .s1_end
   );

   mfb_mul #(.PWR_W(PWR_W), .SEG_W(IDX_W)) i_mul (
      .clk, .rst_n, .s1_valid, .s1_pwr, .s1_wt, .s1_seg, .s1_end,
      .s2_valid, .s2_pwr, .s2_prod, .s2_seg, .s2_end
   );

   mfb_acc_pair #(
      .NUM_FILT(NUM_FILT), .PWR_W(PWR_W), .SEG_W(IDX_W), .ACC_W(ACC_W)
   ) i_acc (
      .clk, .rst_n, .s2_valid, .s2_pwr, .s2_prod, .s2_seg, .s2_end,
      .out_valid, .out_idx, .out_energy
   );

endmodule

// File: rtl/mfb_bank_chk.sv
module mfb_bank_chk #(
   parameter int NUM_FILT = 24,
   parameter int IDX_W    = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             out_valid,
   input logic [IDX_W-1:0] out_idx
);

   logic [IDX_W-1:0] prev_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         prev_idx <= '0;
      else if (out_valid) prev_idx <= (out_idx == IDX_W'(NUM_FILT)) ? '0 : out_idx;
   end

   // R5: a result needs a bin sampled three edges earlier
   a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid, 3));

   // R1: indices stay inside 1..NUM_FILT
   a_r1_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_idx >= IDX_W'(1) && out_idx <= IDX_W'(NUM_FILT)));

   // R1: results come in ascending order, wrapping after the last filter
   a_r1_order: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_idx == prev_idx + IDX_W'(1));

   // R8: no result while reset is held
   always @(posedge clk) begin
      if (!rst_n) a_r8_quiet_in_reset: assert (!out_valid);
   end

endmodule

bind mfb_bank mfb_bank_chk #(.NUM_FILT(NUM_FILT), .IDX_W(IDX_W)) i_mfb_bank_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid), .out_idx(out_idx)
);

// File: tb/test_mfb_bank.sv
`timescale 1ns/1ps
module test_mfb_bank;

   localparam int NB = 256, LO = 2, HI = 254, NF = 24, WARP = 8, PW = 24, AW = 40;
   localparam longint MASK = (64'd1 << PW) - 1;
   localparam int NPAT = 8;
   localparam int PAT_KIND[NPAT] = '{0, 1, 2, 3, 4, 5, 6, 5};
   localparam int PAT_SEED[NPAT] = '{1000, 777, 65535, 0, 37, 12345, 0, 999};
   localparam int PAT_GAP [NPAT] = '{0, 0, 1, 0, 0, 0, 0, 3};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [7:0]    in_bin = '0;
   logic [PW-1:0] in_pwr = '0;
   logic          out_valid;
   logic [4:0]    out_idx;
   logic [AW-1:0] out_energy;

   int     n_chk = 0, n_fail = 0, cyc = 0, n_out = 0;
   int     got_idx[64];
   longint got_dat[64];
   int     got_cyc[64];
   int     drv_cyc[NB];
   int     pe[NF+2];

   mfb_bank i_mfb_bank (.clk, .rst_n, .in_valid, .in_bin, .in_pwr,
                        .out_valid, .out_idx, .out_energy);

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (out_valid && n_out < 64) begin
         got_idx[n_out] = out_idx;
         got_dat[n_out] = longint'(out_energy);
         got_cyc[n_out] = cyc;
         n_out++;
      end
   end

   task automatic check(bit ok, string req, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic longint pwr_of(int kind, int b, int seed);
      case (kind)
         0: return longint'(seed);
         1: return (longint'(b) * seed) & MASK;
         2: return (b % 2 == 1) ? longint'(seed) : 0;
         3: return MASK;
         4: return (b == seed) ? 64'd1000000 : 0;
         5: return ((longint'(b) * 40503 + seed) * 2654435) & MASK;
         default: return (b < pe[0] || b >= pe[NF+1]) ? MASK : 0;
      endcase
   endfunction

   // full weight of filter f at bin b, 16 fraction bits
   function automatic longint full_wt(int f, int b);
      if (b >= pe[f-1] && b < pe[f]) return (longint'(b - pe[f-1]) * 65536) / (pe[f] - pe[f-1]);
      if (b >= pe[f] && b < pe[f+1]) return 65536 - (longint'(b - pe[f]) * 65536) / (pe[f+1] - pe[f]);
      return 0;
   endfunction

   function automatic longint exp_energy(int f, int kind, int seed);
      longint s = 0;
      for (int b = pe[f-1]; b < pe[f+1]; b++) begin
         longint x = pwr_of(kind, b, seed);
         longint w = full_wt(f, b);
         if (f % 2 == 1) s += (x * w) >> 16;
         else            s += x - ((x * (65536 - w)) >> 16);
      end
      return s;
   endfunction

   task automatic send_frame(int kind, int seed, int gap, int settle);
      for (int b = 0; b < NB; b++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_bin   = 8'(b);
         in_pwr   = PW'(pwr_of(kind, b, seed));
         drv_cyc[b] = cyc;
         for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_bin   = 8'(pe[3]);
            in_pwr   = PW'(MASK);
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      repeat (settle) @(negedge clk);
   endtask

   task automatic check_frame(int base, int kind, int seed, string tag);
      for (int i = 0; i < NF; i++) begin
         int f = i + 1;
         longint e = exp_energy(f, kind, seed);
         check(got_idx[base+i] == f, "R1 index order", got_idx[base+i], f);
         check(got_dat[base+i] == e, (f % 2 == 1) ? {"R2 odd energy ", tag} : {"R3 even energy ", tag},
               got_dat[base+i], e);
         check(got_cyc[base+i] == drv_cyc[pe[f+1]-1] + 3, {"R5 R6 latency ", tag},
               got_cyc[base+i], drv_cyc[pe[f+1]-1] + 3);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      for (int j = 0; j < NF + 2; j++)
         pe[j] = LO + ((HI - LO) * j * (j + WARP)) / ((NF + 1) * (NF + 1 + WARP));

      // R8: reset state
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R8 reset out_valid", out_valid, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(out_valid == 1'b0, "R8 idle after reset", out_valid, 0);

      // table walk: R1 R2 R3 R4 (pattern 6) R5 R6 (gaps)
      for (int p = 0; p < NPAT; p++) begin
         n_out = 0;
         send_frame(PAT_KIND[p], PAT_SEED[p], PAT_GAP[p], 6);
         check(n_out == NF, "R1 result count", n_out, NF);
         check_frame(0, PAT_KIND[p], PAT_SEED[p], $sformatf("pattern %0d", p));
      end

      // R4: out-of-band bins alone give no output and no residue
      n_out = 0;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_bin   = 8'((k < 2) ? k : NB - 4 + k);
         in_pwr   = PW'(MASK);
      end
      @(negedge clk);
      in_valid = 1'b0;
      repeat (6) @(negedge clk);
      check(n_out == 0, "R4 no output for out-of-band frame", n_out, 0);
      send_frame(1, 31, 0, 6);
      check_frame(0, 1, 31, "R4 after out-of-band");

      // R7: back-to-back frames
      n_out = 0;
      send_frame(3, 0, 0, 0);
      send_frame(5, 4242, 0, 6);
      check(n_out == 2 * NF, "R7 two frames count", n_out, 2 * NF);
      check_frame(NF, 5, 4242, "R7 second frame");

      // R8: reset in mid-frame
      for (int b = 0; b < 100; b++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_bin   = 8'(b);
         in_pwr   = PW'(MASK);
      end
      @(negedge clk);
      in_valid = 1'b0;
      rst_n    = 1'b0;
      @(negedge clk);
      check(out_valid == 1'b0, "R8 out_valid in reset", out_valid, 0);
      rst_n = 1'b1;
      n_out = 0;
      send_frame(2, 5000, 0, 6);
      check(n_out == NF, "R8 count after reset", n_out, NF);
      check_frame(0, 2, 5000, "R8 after mid-frame reset");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule